// File: doc/BRIEF.md
# Edge-Selectable Integer Clock Prescaler

This block divides the rate of a slow, clock-like input by a programmable integer before it reaches a digital phase detector. The input is asynchronous to the fast system clock. Two flops bring it into the system clock domain, and one further flop holds the previous sample so that transitions can be seen. Only transitions of the chosen polarity are counted. When a full divided period has been counted, the block emits a one-cycle strobe. It also drives a registered square wave at the divided rate.

The modulus register holds the division ratio minus one. A separate enable places a divide-by-2 stage after the 16-bit main counter, which doubles the ratio. The enable is a configuration bit of its own and is not derived from the modulus; it is meant for very fast inputs. All configuration is captured at the start of each divided period, so a change made mid-period never shortens or distorts the period in progress.

Top module: `edge_divider`

## Requirements
- R1: With the divide-by-2 stage off, the ratio is the modulus register value plus one: one strobe every (value+1) selected input edges. A value of 0 gives a strobe on every selected edge.
- R2: A modulus value of 0xFFFF is clamped to a ratio of 65,535, the same as 0xFFFE.
- R3: When `cfg_half` is 1, the total ratio is twice the main ratio. This covers 2 to 131,070.
- R4: `cfg_fall` = 0 counts rising input transitions. `cfg_fall` = 1 counts falling input transitions. Transitions of the other polarity have no effect.
- R5: `div_strobe` is high for exactly one clock cycle per divided period. The input transition that completes a period is first sampled at clock edge k, and the strobe rises at clock edge k+2.
- R6: Let T be the total ratio. For T ≥ 2, `div_square` toggles on the selected edge numbered floor(T/2) within the period and again on edge T. For T = 1 it toggles on every selected edge. Its timing matches `div_strobe`.
- R7: Modulus, divide-by-2 and polarity settings are captured only while no selected edge has yet been counted in the current period. A change made after that takes effect from the next period.
- R8: While the synchronous active-low reset is held, `div_strobe` and `div_square` are 0. Reset clears the counter, the divide-by-2 state and the captured settings, leaving the rising-edge default. Counting restarts from the beginning of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sig_in` |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 1 | Asynchronous input to be divided |
| cfg_modm1 | input | 16 | Division ratio minus one |
| cfg_half | input | 1 | Enables the cascaded divide-by-2 stage |
| cfg_fall | input | 1 | 0: count rising transitions, 1: count falling transitions |
| div_strobe | output | 1 | One-cycle pulse at the end of each divided period |
| div_square | output | 1 | Registered square wave at the divided rate |

## Verification
A behavioural model in the bench predicts the strobe and the square wave on every clock. The corner cases targeted are:
- ratio 1, where a design that waits for a second edge would halve the rate;
- ratio 2 and the doubled stage at modulus 0, where the square-wave midpoint and the terminal count fall on neighbouring edges;
- the clamped maximum, where a counter that wraps or lets 0xFFFF through would end the period one edge late;
- falling-edge counting, where a wrong polarity shifts every strobe by half an input cycle;
- a mid-period change of modulus, stage enable and polarity, where early capture would produce a truncated period;
- a reset in the middle of a period, where leftover count would shorten the first period after reset.

// File: rtl/edge_divider_pkg.sv
// Package: shared width and configuration type for the edge divider.
// Assumes one common counter width for the whole block.
package edge_divider_pkg;

    parameter int DIV_W = 16;

    // Captured configuration of one divided period
    typedef struct packed {
        logic [DIV_W-1:0] modm1;
        logic             half_en;
        logic             fall_sel;
    } div_cfg_t;

    // Terminal count of the main counter; the all-ones code is clamped
    function automatic logic [DIV_W-1:0] clamp_last(input logic [DIV_W-1:0] r);
        return (&r) ? (r - {{(DIV_W-1){1'b0}}, 1'b1}) : r;
    endfunction

endpackage

// File: rtl/edge_divider_sync.sv
// Module: brings the asynchronous input into the system clock domain and
// flags the selected transition polarity. Assumes the input stays in each
// level for at least one system clock period.
module edge_divider_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    input  logic fall_sel,
    output logic edge_hit
);

    localparam int NEWEST = SYNC_STAGES - 1;
    localparam int OLDEST = SYNC_STAGES;

    logic [SYNC_STAGES:0] pipe;
    logic                 rise_seen;
    logic                 fall_seen;

    // Purpose: synchronizer chain plus one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[SYNC_STAGES-1:0], sig_in};
        end
    end

    // Purpose: compare successive synchronized samples against the polarity
    always_comb begin
        rise_seen = pipe[NEWEST] & ~pipe[OLDEST];
        fall_seen = ~pipe[NEWEST] & pipe[OLDEST];
        edge_hit  = fall_sel ? fall_seen : rise_seen;
    end

endmodule

// File: rtl/edge_divider_cfg.sv
// Module: holds the configuration used by the running period. It follows
// the inputs only while the period has not started counting.
// Assumes at_start is high exactly when no edge of the period is counted.
module edge_divider_cfg
    import edge_divider_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             at_start,
    input  logic             edge_hit,
    input  logic [DIV_W-1:0] cfg_modm1,
    input  logic             cfg_half,
    input  logic             cfg_fall,
    output div_cfg_t         cur_cfg,
    output logic [DIV_W-1:0] last_cnt
);

    // Purpose: capture settings between periods, keep them inside one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_cfg <= '0;
        end else if (at_start && !edge_hit) begin
            cur_cfg.modm1    <= cfg_modm1;
            cur_cfg.half_en  <= cfg_half;
            cur_cfg.fall_sel <= cfg_fall;
        end
    end

    // Purpose: terminal count of the main counter after clamping
    always_comb begin
        last_cnt = clamp_last(cur_cfg.modm1);
    end

endmodule

// File: rtl/edge_divider_core.sv
// Module: main modulus counter, cascaded divide-by-2 stage and registered
// outputs. Assumes last_cnt and half_en change only while at_start is high.
module edge_divider_core
    import edge_divider_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_hit,
    input  logic [DIV_W-1:0] last_cnt,
    input  logic             half_en,
    output logic             at_start,
    output logic             div_strobe,
    output logic             div_square
);

    localparam int WX = DIV_W + 1;
    localparam logic [WX-1:0] ONE_X = {{DIV_W{1'b0}}, 1'b1};

    logic [DIV_W-1:0] cnt;
    logic             d2;
    logic [WX-1:0]    ratio_main;
    logic [WX-1:0]    mid_idx;
    logic             tc_main;
    logic             term;
    logic             mid;

    // Purpose: decode terminal count, whole-period end and square midpoint
    always_comb begin
        ratio_main = {1'b0, last_cnt} + ONE_X;
        mid_idx    = (ratio_main >> 1) - ONE_X;
        tc_main    = edge_hit && (cnt == last_cnt);
        term       = tc_main && (!half_en || d2);
        if (half_en) begin
            mid = tc_main && !d2;
        end else begin
            mid = edge_hit && (last_cnt != '0) && ({1'b0, cnt} == mid_idx);
        end
        at_start   = (cnt == '0) && !d2;
    end

    // Purpose: main counter advances on each selected edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (edge_hit) begin
            cnt <= tc_main ? '0 : cnt + {{(DIV_W-1){1'b0}}, 1'b1};
        end
    end

    // Purpose: cascaded divide-by-2 stage toggles at main terminal count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d2 <= 1'b0;
        end else if (tc_main && half_en) begin
            d2 <= ~d2;
        end
    end

    // Purpose: registered strobe and square wave
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_strobe <= 1'b0;
            div_square <= 1'b0;
        end else begin
            div_strobe <= term;
            if (term || mid) begin
                div_square <= ~div_square;
            end
        end
    end

    // R1: the counter never passes the terminal count
    a_r1_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last_cnt);

    // R3: the divide-by-2 state stays clear while the stage is off
    a_r3_half_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !half_en |-> !d2);

endmodule

// File: rtl/edge_divider.sv
// Module: top of the edge-selectable integer prescaler. Synchronizes the
// input, captures settings per period and divides the selected edges.
// Assumes a synchronous active-low reset and a slow asynchronous input.
module edge_divider
    import edge_divider_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic [DIV_W-1:0] cfg_modm1,
    input  logic             cfg_half,
    input  logic             cfg_fall,
    output logic             div_strobe,
    output logic             div_square
);

    div_cfg_t         cur_cfg;
    logic [DIV_W-1:0] last_cnt;
    logic             edge_hit;
    logic             at_start;

    edge_divider_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig_in   (sig_in),
        .fall_sel (cur_cfg.fall_sel),
        .edge_hit (edge_hit)
    );

    edge_divider_cfg cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .at_start  (at_start),
        .edge_hit  (edge_hit),
        .cfg_modm1 (cfg_modm1),
        .cfg_half  (cfg_half),
        .cfg_fall  (cfg_fall),
        .cur_cfg   (cur_cfg),
        .last_cnt  (last_cnt)
    );

    edge_divider_core core_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_hit   (edge_hit),
        .last_cnt   (last_cnt),
        .half_en    (cur_cfg.half_en),
        .at_start   (at_start),
        .div_strobe (div_strobe),
        .div_square (div_square)
    );

    // R5: the strobe lasts one cycle
    a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        div_strobe |=> !div_strobe);

    // R5: every strobe follows a counted edge
    a_r5_strobe_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        div_strobe |-> $past(edge_hit));

    // R7: captured settings hold once the period has begun counting
    a_r7_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(at_start) |-> $stable(cur_cfg));

endmodule

// File: tb/edge_divider_tb_top.sv
// Bench: drives the input with different settings, predicts the outputs
// with a behavioural edge-counting model and compares them on every clock.
module edge_divider_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sig_in = 1'b0;
    logic [15:0] cfg_modm1 = '0;
    logic        cfg_half = 1'b0;
    logic        cfg_fall = 1'b0;
    logic        div_strobe;
    logic        div_square;

    int checks = 0;
    int errors = 0;
    int stb_seen = 0;
    bit done = 1'b0;

    // behavioural model state
    int   cnt_m = 0;
    int   t_m = 1;
    logic pol_m = 1'b0;
    logic sq_m = 1'b0;
    logic prev_v = 1'b0;
    logic dl_stb [3];
    logic dl_sq  [3];

    always #5 clk = ~clk;

    edge_divider dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sig_in     (sig_in),
        .cfg_modm1  (cfg_modm1),
        .cfg_half   (cfg_half),
        .cfg_fall   (cfg_fall),
        .div_strobe (div_strobe),
        .div_square (div_square)
    );

    function automatic int total_ratio(input logic [15:0] m, input logic h);
        int n;
        n = (m == 16'hFFFF) ? 65535 : int'(m) + 1;
        return h ? 2 * n : n;
    endfunction

    task automatic clear_model();
        cnt_m = 0; t_m = 1; pol_m = 1'b0; sq_m = 1'b0; prev_v = 1'b0;
        for (int i = 0; i < 3; i++) begin
            dl_stb[i] = 1'b0;
            dl_sq[i]  = 1'b0;
        end
    endtask

    // One clock: compare outputs, drive the input, advance the model
    task automatic step(input logic v);
        logic er, ef, pol, hit, stb;
        @(negedge clk);
        checks++;
        if (div_strobe !== dl_stb[2]) begin
            errors++;
            $display("FAIL R5 strobe at %0t: got %b expected %b", $time, div_strobe, dl_stb[2]);
        end
        checks++;
        if (div_square !== dl_sq[2]) begin
            errors++;
            $display("FAIL R6 square at %0t: got %b expected %b", $time, div_square, dl_sq[2]);
        end
        if (div_strobe === 1'b1) stb_seen++;
        sig_in = v;
        er = v && !prev_v;
        ef = !v && prev_v;
        prev_v = v;
        pol = (cnt_m == 0) ? cfg_fall : pol_m;
        hit = pol ? ef : er;
        stb = 1'b0;
        if (hit) begin
            if (cnt_m == 0) begin
                pol_m = cfg_fall;
                t_m   = total_ratio(cfg_modm1, cfg_half);
            end
            cnt_m++;
            if (cnt_m == t_m || (t_m >= 2 && cnt_m == t_m / 2)) sq_m = !sq_m;
            if (cnt_m == t_m) begin
                stb   = 1'b1;
                cnt_m = 0;
            end
        end
        dl_stb[2] = dl_stb[1]; dl_stb[1] = dl_stb[0]; dl_stb[0] = stb;
        dl_sq[2]  = dl_sq[1];  dl_sq[1]  = dl_sq[0];  dl_sq[0]  = sq_m;
    endtask

    // R8: hold reset, outputs must stay low
    task automatic reset_dut();
        @(negedge clk);
        rst_n  = 1'b0;
        sig_in = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            checks++;
            if (div_strobe !== 1'b0 || div_square !== 1'b0) begin
                errors++;
                $display("FAIL R8 reset outputs: got %b%b expected 00", div_strobe, div_square);
            end
        end
        @(negedge clk);
        rst_n = 1'b1;
        clear_model();
        stb_seen = 0;
    endtask

    task automatic set_cfg(input logic [15:0] m, input logic h, input logic f);
        cfg_modm1 = m; cfg_half = h; cfg_fall = f;
        repeat (4) step(1'b0);
    endtask

    task automatic run(input int ncyc, input int hp);
        for (int i = 0; i < ncyc; i++) begin
            repeat (hp) step(1'b1);
            repeat (hp) step(1'b0);
        end
        repeat (5) step(1'b0);
    endtask

    task automatic check_count(input int expv, input string what);
        checks++;
        if (stb_seen != expv) begin
            errors++;
            $display("FAIL %s: got %0d strobes expected %0d", what, stb_seen, expv);
        end
        stb_seen = 0;
    endtask

    initial begin
        clear_model();
        reset_dut();                                   // R8
        set_cfg(16'd0, 1'b0, 1'b0);  run(6, 2);   check_count(6, "R1 ratio 1");
        set_cfg(16'd1, 1'b0, 1'b1);  run(8, 2);   check_count(4, "R4 falling ratio 2");
        set_cfg(16'd5, 1'b1, 1'b0);  run(36, 1);  check_count(3, "R3 ratio 12");
        set_cfg(16'd0, 1'b1, 1'b0);  run(10, 2);  check_count(5, "R3 ratio 2 from modulus 0");
        set_cfg(16'd37, 1'b1, 1'b1); run(152, 3); check_count(2, "R4 falling ratio 76");
        // R7: change everything after two of five edges
        set_cfg(16'd4, 1'b0, 1'b0);  run(2, 4);
        set_cfg(16'd9, 1'b1, 1'b1);  run(3, 4);   check_count(1, "R7 old period kept");
        run(19, 4);                               check_count(1, "R7 new period ratio 20");
        // R8: reset in the middle of a period restarts the count
        set_cfg(16'd9, 1'b0, 1'b0);  run(4, 2);
        reset_dut();
        set_cfg(16'd9, 1'b0, 1'b0);  run(9, 2);   check_count(0, "R8 no early strobe");
        run(1, 2);                                check_count(1, "R8 full period after reset");
        // R2: clamped maximum
        set_cfg(16'hFFFF, 1'b0, 1'b0); run(65534, 1); check_count(0, "R2 no strobe before 65535");
        run(1, 1);                                    check_count(1, "R2 strobe at 65535");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(195_000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule